// File: doc/BRIEF.md
# Recirculating Pulse Pass Counter with Loop Select

This block controls the recirculating loop of a pulse-based clock multiplier. Every reference pulse that enters the delay loop should travel round it a fixed number of times, eight by default. The output pulse rate is then that many times the reference rate. Both pulse events arrive as single-cycle strobes on the system clock: `ref_strobe` for a fresh reference pulse and `loop_strobe` for a pulse coming back out of the loop.

The block counts the passes and flags the final pass with a one-cycle strobe, `eighth`, which is the moment a downstream phase comparison may run. It drives `sel`: high opens the loop to a fresh reference pulse, low closes it so the pulse keeps circulating.

The lock controller sets `lock_mode`, which picks one of two `sel` policies. During the binary-search phase (`lock_mode` = 0), `sel` flips after each reference pulse ends. During tracking (`lock_mode` = 1), `sel` is held high from the final pass until the next reference pulse, so a stray extra pass cannot get back into the loop.

Top module: `pulse_loop_ctrl`

## Requirements
- R1: During synchronous reset (`rst` = 1) and in the first cycle after it, `pass_cnt` is 0, `eighth` is 0 and `sel` is 1, in both modes.
- R2: A `loop_strobe` that is counted raises `pass_cnt` by one in the next cycle. `pass_cnt` never exceeds PASSES (8).
- R3: `eighth` is 1 in exactly the one cycle in which `pass_cnt` equals 8. In the cycle after that, `pass_cnt` is back to 0.
- R4: A `ref_strobe` makes `pass_cnt` 0 in the next cycle. This holds even when a `loop_strobe` arrives in the same cycle.
- R5: With `lock_mode` = 0, `sel` changes value two cycles after each `ref_strobe`, which is the cycle after the strobe's falling edge. In this mode every `loop_strobe` below the limit is counted, whatever the value of `sel`.
- R6: With `lock_mode` = 1, `sel` is 1 combinationally in a `ref_strobe` cycle and in the cycle the 8th `loop_strobe` arrives. It stays 1 from then until the next `ref_strobe`, and is 0 at all other times.
- R7: With `lock_mode` = 1, a `loop_strobe` that arrives after the 8th pass and before the next `ref_strobe` is not counted. `pass_cnt` stays 0 and `eighth` does not rise.
- R8: With `lock_mode` = 1, one `ref_strobe` followed by eight `loop_strobe`s gives exactly one `eighth` pulse.
- R9: `lock_mode` = 1 selects the tracking policy for `sel` and `lock_mode` = 0 selects the search policy. It is sampled every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lock_mode | input | 1 | 1 = tracking policy, 0 = search policy |
| ref_strobe | input | 1 | Single-cycle strobe for a reference pulse |
| loop_strobe | input | 1 | Single-cycle strobe for a pulse leaving the loop |
| pass_cnt | output | CW (4) | Number of passes completed by the current pulse |
| eighth | output | 1 | One-cycle strobe on the final pass |
| sel | output | 1 | 1 = inject reference pulse, 0 = loop closed |

## Verification
The hardest case to reach is the extra ninth pass in tracking mode. It needs a full run of eight counted passes and then one more `loop_strobe` before the next reference pulse. The stimulus sends one reference pulse and eight spaced loop strobes, then a ninth strobe. It checks that the count stays at zero and that `sel` stays high. A second hard case is a reference strobe that lands in the same cycle as a loop strobe in the middle of a count. The bench drives both in one cycle after three passes.

// File: rtl/pulse_loop_ctrl.sv
module pulse_loop_ctrl #(
  parameter int PASSES = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lock_mode,
  input  logic          ref_strobe,
  input  logic          loop_strobe,
  output logic [CW-1:0] pass_cnt,
  output logic          eighth,
  output logic          sel
);
  localparam logic [CW-1:0] LAST = CW'(PASSES);
  localparam logic [CW-1:0] PREV = CW'(PASSES - 1);

  logic [CW-1:0] cnt;
  logic hold, tog, ref_q;

  wire full = (cnt == LAST);
  wire adv = loop_strobe & ~ref_strobe & ~full & ~(lock_mode & hold);
  wire final_pass = adv & (cnt == PREV);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      hold  <= 1'b1;
      tog   <= 1'b1;
      ref_q <= 1'b0;
    end else begin
      ref_q <= ref_strobe;
      if (ref_strobe)  cnt <= '0;
      else if (full)   cnt <= '0;
      else if (adv)    cnt <= cnt + 1'b1;
      if (ref_strobe)                    hold <= 1'b0;
      else if (final_pass && lock_mode)  hold <= 1'b1;
      if (!lock_mode && ref_q && !ref_strobe) tog <= ~tog;
    end
  end

  assign pass_cnt = cnt;
  assign eighth   = full;
  assign sel      = lock_mode ? (ref_strobe | hold | final_pass) : tog;

  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (rst)
    pass_cnt <= LAST);

  assert_single_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    eighth |=> !eighth && pass_cnt == 0);

  assert_restart_R4: assert property (@(posedge clk) disable iff (rst)
    ref_strobe |=> pass_cnt == 0);

  assert_search_toggle_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !lock_mode && $past(ref_strobe) && !ref_strobe)
      |=> (lock_mode || sel != $past(sel)));

  assert_open_after_last_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && lock_mode && $past(lock_mode) && eighth) |-> sel);

  assert_no_ninth_R7: assert property (@(posedge clk) disable iff (rst)
    (lock_mode && sel && !ref_strobe && loop_strobe && pass_cnt != PREV)
      |=> (pass_cnt == 0 || pass_cnt == $past(pass_cnt)));
endmodule

// File: tb/sim_pulse_loop_ctrl.sv
module sim_pulse_loop_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock_mode = 1'b1;
  logic ref_strobe = 1'b0;
  logic loop_strobe = 1'b0;
  logic [3:0] pass_cnt;
  logic eighth, sel;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int e8_seen = 0;
  bit done = 1'b0;

  int    q_cyc[$];
  int    q_sig[$];
  int    q_val[$];
  string q_req[$];

  pulse_loop_ctrl u0 (.clk(clk), .rst(rst), .lock_mode(lock_mode),
    .ref_strobe(ref_strobe), .loop_strobe(loop_strobe),
    .pass_cnt(pass_cnt), .eighth(eighth), .sel(sel));

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // sig: 0 = pass_cnt, 1 = eighth, 2 = sel
  task automatic ex(input int sig, input int val, input int ofs, input string req);
    q_cyc.push_back(cyc + ofs); q_sig.push_back(sig);
    q_val.push_back(val); q_req.push_back(req);
  endtask

  task automatic step(input logic r, input logic l);
    ref_strobe = r; loop_strobe = l;
    @(posedge clk); #1;
    ref_strobe = 1'b0; loop_strobe = 1'b0;
  endtask

  always @(negedge clk) begin
    if (eighth) e8_seen++;
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      int s, v, a;
      string r;
      s = q_sig.pop_front(); v = q_val.pop_front(); r = q_req.pop_front();
      void'(q_cyc.pop_front());
      a = (s == 0) ? int'(pass_cnt) : (s == 1) ? int'(eighth) : int'(sel);
      checks++;
      if (a !== v) begin
        fails++;
        $display("FAIL %s sig%0d cycle %0d: actual %0d expected %0d", r, s, cyc, a, v);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    step(0, 0); step(0, 0);
    ex(0, 0, 0, "R1"); ex(1, 0, 0, "R1"); ex(2, 1, 0, "R1");
    rst = 1'b0;
    ex(0, 0, 0, "R1"); ex(1, 0, 0, "R1"); ex(2, 1, 0, "R1");
    step(0, 0);

    // tracking mode: one full round of eight passes (R6, R8, R9)
    e8_seen = 0;
    ex(2, 1, 0, "R6"); ex(0, 0, 1, "R4");
    step(1, 0);
    ex(2, 0, 0, "R9");
    step(0, 0);
    for (int i = 1; i <= 8; i++) begin
      if (i == 8) begin
        ex(2, 1, 0, "R6"); ex(1, 1, 1, "R3"); ex(0, 8, 1, "R2");
      end else begin
        ex(2, 0, 0, "R6"); ex(0, i, 1, "R2");
      end
      step(0, 1);
      if (i < 8) step(0, 0);
    end
    ex(1, 0, 1, "R3"); ex(0, 0, 1, "R3"); ex(2, 1, 0, "R6");
    step(0, 0);
    ex(0, 0, 1, "R7"); ex(2, 1, 0, "R7"); ex(1, 0, 1, "R7");
    step(0, 1);
    step(0, 0); step(0, 0);
    checks++;
    if (e8_seen != 1) begin
      fails++;
      $display("FAIL R8: actual %0d final-pass strobes expected 1", e8_seen);
    end

    // restart overrides a simultaneous loop strobe
    step(1, 0);
    for (int i = 1; i <= 3; i++) begin
      ex(0, i, 1, "R2"); step(0, 1);
    end
    ex(0, 0, 1, "R4");
    step(1, 1);
    step(0, 0);

    // search mode
    lock_mode = 1'b0;
    ex(2, 1, 0, "R9");
    step(0, 0);
    ex(2, 1, 0, "R5"); ex(2, 1, 1, "R5"); ex(2, 0, 2, "R5");
    step(1, 0);
    step(0, 0); step(0, 0);
    for (int i = 1; i <= 8; i++) begin
      ex(0, i, 1, "R5"); step(0, 1);
    end
    ex(1, 1, 0, "R3"); ex(0, 0, 1, "R3"); ex(1, 0, 1, "R3");
    step(0, 0);
    ex(2, 0, 0, "R5"); ex(2, 0, 1, "R5"); ex(2, 1, 2, "R5");
    step(1, 0);
    step(0, 0); step(0, 0); step(0, 0);

    // reset again in search mode
    rst = 1'b1;
    step(0, 1);
    rst = 1'b0;
    ex(0, 0, 0, "R1"); ex(2, 1, 0, "R1");
    step(0, 0); step(0, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule